// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block lets a host move data into or out of local packet RAM one access at a time through a single data port. The host programs a 16-bit start address and a 16-bit byte count through 8-bit registers, picks byte or 16-bit word mode, and then issues a read or write command. After that, every data-port access by the host causes exactly one local RAM access. The engine then advances the current address and lowers the remaining count by the transfer width.

When the remaining count reaches zero the engine sets a sticky completion flag, which the host clears by writing a one to it. During a read the engine fetches the first unit from RAM as soon as the command is issued, so the host's first data-port read does not have to wait. The current address can be read back at any moment. An abort command stops a transfer at once. A byte-swap option exchanges the two bytes of each word in word mode.

Local RAM is treated as byte addressed and little-endian. A word access at address `a` covers byte `a` on the low lane and byte `a+1` on the high lane. Reads have one clock of latency.

Top module: `rdma_port_engine`

## Requirements
- R1: The start address is held at register offsets 0x1 (low byte) and 0x2 (high byte). The byte count is held at offsets 0x3 (low) and 0x4 (high). Each register reads back the value last written to it.
- R2: Writing offset 0x0 issues a command from bits [2:0]: 001 starts a read, 010 starts a write, and any value with bit 2 set aborts. The values 000 and 011 change neither the address, the completion flag nor any RAM activity.
- R3: In a write, each data-port write stores one unit at the current address and then advances the address by the width. Byte mode stores `dp_wdata[7:0]` at the address with `ram_be`=01. Word mode stores `dp_wdata[7:0]` at the address and `dp_wdata[15:8]` at address+1, with `ram_be`=11.
- R4: In a read, the first unit is fetched when the command is issued, so `dp_rdata` is valid from the second cycle after the command write. Each data-port read returns the next unit (byte mode: `{8'h00, byte}`; word mode: `{byte[a+1], byte[a]}`). The engine makes exactly as many RAM reads as there are units and never reads past the last one.
- R5: Status offset 0x5 bit 6 (mask 0x40), which is mirrored on `rdma_done`, sets when the remaining count reaches zero. This includes a command issued with a count of zero, which makes no RAM access. Writing 1 to bit 6 clears it, and a set in the same cycle wins over the clear.
- R6: The current address is readable at offsets 0x6 (low) and 0x7 (high) at any time, including in the middle of a transfer.
- R7: Configuration offset 0x8 bit 0 selects word mode, in which each access moves 2 bytes and an odd byte count is rounded up to the next even value.
- R8: An abort stops the transfer immediately. Later data-port accesses make no RAM access, leave the address unchanged and do not set the completion flag.
- R9: Once the count is exhausted, further data-port accesses make no RAM access and leave the address unchanged.
- R10: Configuration offset 0x8 bit 1 swaps the two bytes of each word in both directions in word mode, and has no effect in byte mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dp_rd | input | 1 | Data-port read strobe, one cycle per access |
| dp_wr | input | 1 | Data-port write strobe, one cycle per access |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data-port read data |
| ram_en | output | 1 | Local RAM access enable |
| ram_we | output | 1 | Local RAM write enable |
| ram_be | output | 2 | Byte-lane enables for writes |
| ram_addr | output | ADDR_W | Local RAM byte address |
| ram_wdata | output | 16 | Local RAM write data |
| ram_rdata | input | 16 | Local RAM read data, one cycle after the access |
| rdma_done | output | 1 | Completion flag |

## Verification
The hardest situations to reach are the ones at the edges of the transfer window. These are the cycle just after a read command, when the only valid data is the prefetched unit, and the accesses that arrive after the last unit or after an abort. In those cases the visible effect is something that does not happen.

The bench drives data-port reads starting in the earliest permitted cycle. It counts every RAM access in its own memory model, and after each transfer it issues one surplus access. It then compares the address and the access count before and after that access. Random transfers vary the direction, width, swap, start address and odd or even count, and directed cases cover a zero count, an abort in the middle of a transfer and the command codes that must have no effect.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

   localparam logic [3:0] RA_CMD    = 4'h0;
   localparam logic [3:0] RA_SA_LO  = 4'h1;
   localparam logic [3:0] RA_SA_HI  = 4'h2;
   localparam logic [3:0] RA_CNT_LO = 4'h3;
   localparam logic [3:0] RA_CNT_HI = 4'h4;
   localparam logic [3:0] RA_STAT   = 4'h5;
   localparam logic [3:0] RA_CUR_LO = 4'h6;
   localparam logic [3:0] RA_CUR_HI = 4'h7;
   localparam logic [3:0] RA_CFG    = 4'h8;

   localparam int DONE_BIT = 6;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2,
      OP_ABORT = 2'd3
   } op_e;

   function automatic op_e op_decode(input logic [2:0] c);
      if (c[2])              return OP_ABORT;
      else if (c == 3'b001)  return OP_READ;
      else if (c == 3'b010)  return OP_WRITE;
      else                   return OP_NONE;
   endfunction

endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
   import rdma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              cmd_stb,
   output op_e               cmd_op,
   output logic [ADDR_W-1:0] start_addr,
   output logic [CNT_W-1:0]  xfer_cnt,
   output logic              word_mode,
   output logic              swap_en,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic              done_set,
   output logic              done
);

   logic [ADDR_W-1:0] sa_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [2:0]        cmd_q;
   logic [1:0]        cfg_q;
   logic              done_q;
   logic [15:0]       sa_w, cnt_w, cur_w;
   logic              clr_req;

   assign cmd_stb    = reg_we && (reg_addr == RA_CMD);
   assign cmd_op     = op_decode(reg_wdata[2:0]);
   assign start_addr = sa_q;
   assign xfer_cnt   = cnt_q;
   assign word_mode  = cfg_q[0];
   assign swap_en    = cfg_q[1];
   assign done       = done_q;
   assign clr_req    = reg_we && (reg_addr == RA_STAT) && reg_wdata[DONE_BIT];

   assign sa_w  = 16'(sa_q);
   assign cnt_w = 16'(cnt_q);
   assign cur_w = 16'(cur_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sa_q   <= '0;
         cnt_q  <= '0;
         cmd_q  <= '0;
         cfg_q  <= '0;
         done_q <= 1'b0;
      end else begin
         if (reg_we) begin
            case (reg_addr)
               RA_CMD:    cmd_q <= reg_wdata[2:0];
               RA_SA_LO:  sa_q  <= ADDR_W'({sa_w[15:8], reg_wdata});
               RA_SA_HI:  sa_q  <= ADDR_W'({reg_wdata, sa_w[7:0]});
               RA_CNT_LO: cnt_q <= CNT_W'({cnt_w[15:8], reg_wdata});
               RA_CNT_HI: cnt_q <= CNT_W'({reg_wdata, cnt_w[7:0]});
               RA_CFG:    cfg_q <= reg_wdata[1:0];
               default: ;
            endcase
         end
         if (done_set)     done_q <= 1'b1;
         else if (clr_req) done_q <= 1'b0;
      end
   end

   always_comb begin
      case (reg_addr)
         RA_CMD:    reg_rdata = {5'b0, cmd_q};
         RA_SA_LO:  reg_rdata = sa_w[7:0];
         RA_SA_HI:  reg_rdata = sa_w[15:8];
         RA_CNT_LO: reg_rdata = cnt_w[7:0];
         RA_CNT_HI: reg_rdata = cnt_w[15:8];
         RA_STAT:   reg_rdata = {1'b0, done_q, 6'b0};
         RA_CUR_LO: reg_rdata = cur_w[7:0];
         RA_CUR_HI: reg_rdata = cur_w[15:8];
         RA_CFG:    reg_rdata = {6'b0, cfg_q};
         default:   reg_rdata = 8'h00;
      endcase
   end

   AST_DONE_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      done_set |=> done_q); // R5
   AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !done_set) |=> !done_q); // R5

endmodule

// File: rtl/rdma_seq.sv
module rdma_seq
   import rdma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_stb,
   input  op_e               cmd_op,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  xfer_cnt,
   input  logic              word_mode,
   input  logic              dp_rd,
   input  logic              dp_wr,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              ram_en,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              load_pend,
   output logic              done_set
);

   localparam int RW = CNT_W + 1;

   logic              active_q, rd_q, pf_q, lp_q;
   logic [ADDR_W-1:0] cur_q, astep;
   logic [RW-1:0]     rem_q, step_c, rounded_c, rem_next;
   logic              is_go, acc, last;

   assign step_c    = word_mode ? RW'(2) : RW'(1);
   assign astep     = word_mode ? ADDR_W'(2) : ADDR_W'(1);
   assign rounded_c = RW'(xfer_cnt) + (word_mode ? RW'(xfer_cnt[0]) : RW'(0));
   assign is_go     = cmd_stb && (cmd_op == OP_READ || cmd_op == OP_WRITE);
   assign acc       = active_q && !cmd_stb && (rd_q ? (dp_rd && !pf_q) : dp_wr);
   assign rem_next  = rem_q - step_c;
   assign last      = (rem_next == '0);

   assign done_set  = (is_go && rounded_c == '0) || (acc && last);
   assign ram_en    = active_q && !cmd_stb && (pf_q || (acc && (!rd_q || !last)));
   assign ram_we    = acc && !rd_q;
   assign ram_addr  = (pf_q || !rd_q) ? cur_q : cur_q + astep;
   assign cur_addr  = cur_q;
   assign load_pend = lp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rd_q     <= 1'b0;
         pf_q     <= 1'b0;
         lp_q     <= 1'b0;
         cur_q    <= '0;
         rem_q    <= '0;
      end else begin
         lp_q <= ram_en && !ram_we;
         if (cmd_stb) begin
            case (cmd_op)
               OP_READ, OP_WRITE: begin
                  cur_q    <= start_addr;
                  rem_q    <= rounded_c;
                  active_q <= (rounded_c != '0);
                  rd_q     <= (cmd_op == OP_READ);
                  pf_q     <= (cmd_op == OP_READ) && (rounded_c != '0);
               end
               OP_ABORT: begin
                  active_q <= 1'b0;
                  pf_q     <= 1'b0;
               end
               default: ;
            endcase
         end else begin
            pf_q <= 1'b0;
            if (acc) begin
               cur_q <= cur_q + astep;
               rem_q <= rem_next;
               if (last) active_q <= 1'b0;
            end
         end
      end
   end

   AST_RAM_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ram_en |-> active_q); // R9
   AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (cur_q == $past(cur_q) + $past(astep))); // R3
   AST_IDLE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !cmd_stb) |=> $stable(cur_q)); // R9
   AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb && cmd_op == OP_ABORT) |=> !ram_en); // R8
   AST_NO_ZERO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (rem_q != '0)); // R5

endmodule

// File: rtl/rdma_lane.sv
module rdma_lane #(
   parameter bit HAS_SWAP = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load_pend,
   input  logic [15:0] ram_rdata,
   input  logic        word_mode,
   input  logic        swap_en,
   input  logic [15:0] dp_wdata,
   output logic [15:0] dp_rdata,
   output logic [15:0] ram_wdata,
   output logic [1:0]  ram_be
);

   logic [15:0] pref_q, raw;
   logic        do_swap;

   generate
      if (HAS_SWAP) begin : g_swap
         assign do_swap = word_mode && swap_en;
      end else begin : g_noswap
         assign do_swap = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pref_q <= '0;
      else if (load_pend) pref_q <= ram_rdata;
   end

   assign raw = load_pend ? ram_rdata : pref_q;

   always_comb begin
      if (!word_mode)   dp_rdata = {8'h00, raw[7:0]};
      else if (do_swap) dp_rdata = {raw[7:0], raw[15:8]};
      else              dp_rdata = raw;
      if (!word_mode)   ram_wdata = {8'h00, dp_wdata[7:0]};
      else if (do_swap) ram_wdata = {dp_wdata[7:0], dp_wdata[15:8]};
      else              ram_wdata = dp_wdata;
   end

   assign ram_be = word_mode ? 2'b11 : 2'b01;

   AST_PREF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_pend |=> $stable(pref_q)); // R4

endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
   import rdma_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int CNT_W    = 16,
   parameter bit HAS_SWAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              dp_rd,
   input  logic              dp_wr,
   input  logic [15:0]       dp_wdata,
   output logic [15:0]       dp_rdata,
   output logic              ram_en,
   output logic              ram_we,
   output logic [1:0]        ram_be,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [15:0]       ram_wdata,
   input  logic [15:0]       ram_rdata,
   output logic              rdma_done
);

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr_w
         $error("rdma_port_engine: ADDR_W must lie in 9..16");
      end
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt_w
         $error("rdma_port_engine: CNT_W must lie in 9..16");
      end
   endgenerate

   logic              cmd_stb, word_mode, swap_en, load_pend, done_set;
   op_e               cmd_op;
   logic [ADDR_W-1:0] start_addr, cur_addr;
   logic [CNT_W-1:0]  xfer_cnt;

   rdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_stb(cmd_stb),
      .cmd_op(cmd_op), .start_addr(start_addr), .xfer_cnt(xfer_cnt),
      .word_mode(word_mode), .swap_en(swap_en), .cur_addr(cur_addr),
      .done_set(done_set), .done(rdma_done)
   );

   rdma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
      .start_addr(start_addr), .xfer_cnt(xfer_cnt), .word_mode(word_mode),
      .dp_rd(dp_rd), .dp_wr(dp_wr), .cur_addr(cur_addr), .ram_en(ram_en),
      .ram_we(ram_we), .ram_addr(ram_addr), .load_pend(load_pend),
      .done_set(done_set)
   );

   rdma_lane #(.HAS_SWAP(HAS_SWAP)) u_lane (
      .clk(clk), .rst_n(rst_n), .load_pend(load_pend), .ram_rdata(ram_rdata),
      .word_mode(word_mode), .swap_en(swap_en), .dp_wdata(dp_wdata),
      .dp_rdata(dp_rdata), .ram_wdata(ram_wdata), .ram_be(ram_be)
   );

endmodule

// File: tb/rdma_port_engine_tb.sv
module rdma_port_engine_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        dp_rd = 1'b0, dp_wr = 1'b0;
   logic [15:0] dp_wdata = '0;
   logic [15:0] dp_rdata;
   logic        ram_en, ram_we, rdma_done;
   logic [1:0]  ram_be;
   logic [15:0] ram_addr, ram_wdata;
   logic [15:0] ram_rdata = '0;
   logic [15:0] ram_a1;

   int errs = 0;
   int checks = 0;
   int ram_acc = 0;
   logic [7:0] mem [0:65535];

   always #5 clk = ~clk;

   rdma_port_engine dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_rd(dp_rd),
      .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
      .ram_en(ram_en), .ram_we(ram_we), .ram_be(ram_be), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .rdma_done(rdma_done)
   );

   assign ram_a1 = ram_addr + 16'd1;

   always @(posedge clk) begin
      if (ram_en) begin
         ram_acc <= ram_acc + 1;
         if (ram_we) begin
            if (ram_be[0]) mem[ram_addr] <= ram_wdata[7:0];
            if (ram_be[1]) mem[ram_a1]   <= ram_wdata[15:8];
         end else begin
            ram_rdata <= {mem[ram_a1], mem[ram_addr]};
         end
      end
   end

   function automatic logic [7:0] pat(input logic [15:0] a);
      return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h5A;
   endfunction

   function automatic logic [15:0] exp_rd(input logic [15:0] a, input bit word, input bit swap);
      logic [15:0] a1;
      a1 = a + 16'd1;
      if (!word) return {8'h00, mem[a]};
      if (swap)  return {mem[a], mem[a1]};
      return {mem[a1], mem[a]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rw(input logic [3:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rr(input logic [3:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic get_cur(output logic [15:0] c);
      logic [7:0] lo, hi;
      rr(4'h6, lo);
      rr(4'h7, hi);
      c = {hi, lo};
   endtask

   task automatic get_done(output logic d);
      logic [7:0] s;
      rr(4'h5, s);
      d = s[6];
   endtask

   task automatic dpr(output logic [15:0] d);
      dp_rd = 1'b1;
      #1;
      d = dp_rdata;
      @(negedge clk);
      dp_rd = 1'b0;
   endtask

   task automatic dpw(input logic [15:0] d);
      dp_wr = 1'b1; dp_wdata = d;
      @(negedge clk);
      dp_wr = 1'b0;
   endtask

   task automatic setup(input bit word, input bit swap, input logic [15:0] a, input logic [15:0] cnt);
      rw(4'h8, {6'b0, swap, word});
      rw(4'h1, a[7:0]);
      rw(4'h2, a[15:8]);
      rw(4'h3, cnt[7:0]);
      rw(4'h4, cnt[15:8]);
      rw(4'h5, 8'h40);
   endtask

   task automatic xfer(input bit is_rd, input bit word, input bit swap,
                       input logic [15:0] a, input logic [15:0] cnt);
      int units, step, acc0, acc1;
      logic [15:0] d, c, ak, ak1, cend;
      logic [15:0] wdat [0:63];
      logic dn;
      string tg;
      step  = word ? 2 : 1;
      units = word ? (int'(cnt) + 1) / 2 : int'(cnt);
      tg    = (word && swap) ? "R10" : (word ? "R7" : (is_rd ? "R4" : "R3"));
      setup(word, swap, a, cnt);
      acc0 = ram_acc;
      rw(4'h0, is_rd ? 8'h01 : 8'h02);
      if (is_rd) @(negedge clk);
      for (int k = 0; k < units; k++) begin
         ak = a + 16'(k * step);
         if (is_rd) begin
            dpr(d);
            chk(tg, {16'h0, d}, {16'h0, exp_rd(ak, word, swap)});
         end else begin
            wdat[k] = 16'($urandom);
            dpw(wdat[k]);
         end
         if (k == 0) begin
            get_cur(c);
            chk("R6 mid", {16'h0, c}, {16'h0, a + 16'(step)});
         end
      end
      cend = a + 16'(units * step);
      get_cur(c);
      chk("R6 end", {16'h0, c}, {16'h0, cend});
      get_done(dn);
      chk("R5 done", {31'h0, dn}, 32'h1);
      chk(is_rd ? "R4 count" : "R3 count", ram_acc - acc0, units);
      if (!is_rd) begin
         for (int k = 0; k < units; k++) begin
            ak  = a + 16'(k * step);
            ak1 = ak + 16'd1;
            if (!word)     chk("R3 byte", {24'h0, mem[ak]}, {24'h0, wdat[k][7:0]});
            else if (swap) chk("R10 wr", {16'h0, mem[ak], mem[ak1]}, {16'h0, wdat[k]});
            else           chk("R7 wr",  {16'h0, mem[ak1], mem[ak]}, {16'h0, wdat[k]});
         end
      end
      acc1 = ram_acc;
      if (is_rd) dpr(d); else dpw(16'hBEEF);
      chk("R9 ram", ram_acc, acc1);
      get_cur(c);
      chk("R9 addr", {16'h0, c}, {16'h0, cend});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [7:0] r;
      logic [15:0] c, d;
      logic dn;
      int acc0;
      void'($urandom(32'h0C0FFEE5));
      for (int i = 0; i < 65536; i++) mem[i] = pat(16'(i));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rr(4'h5, r);  chk("R5 reset", {24'h0, r}, 32'h0);
      get_cur(c);   chk("R6 reset", {16'h0, c}, 32'h0);
      rr(4'h8, r);  chk("R7 reset cfg", {24'h0, r}, 32'h0);

      // R1 readback
      setup(1'b0, 1'b0, 16'h1234, 16'h0A05);
      rr(4'h1, r); chk("R1 sa lo", {24'h0, r}, 32'h34);
      rr(4'h2, r); chk("R1 sa hi", {24'h0, r}, 32'h12);
      rr(4'h3, r); chk("R1 cnt lo", {24'h0, r}, 32'h05);
      rr(4'h4, r); chk("R1 cnt hi", {24'h0, r}, 32'h0A);

      // directed transfers
      xfer(1'b0, 1'b0, 1'b0, 16'h0100, 16'd7);
      rw(4'h5, 8'h40);
      get_done(dn); chk("R5 w1c", {31'h0, dn}, 32'h0);
      xfer(1'b1, 1'b1, 1'b0, 16'h0200, 16'd5);
      xfer(1'b1, 1'b1, 1'b1, 16'h0300, 16'd4);
      xfer(1'b0, 1'b1, 1'b1, 16'h0400, 16'd6);
      xfer(1'b1, 1'b0, 1'b1, 16'h0500, 16'd3);
      xfer(1'b0, 1'b1, 1'b0, 16'hFFFE, 16'd4);

      // R2: codes 000 and 011 have no effect
      get_cur(c);
      acc0 = ram_acc;
      rw(4'h5, 8'h40);
      rw(4'h0, 8'h03);
      rw(4'h0, 8'h00);
      dpr(d);
      dpw(16'h1111);
      get_cur(d);
      chk("R2 addr", {16'h0, d}, {16'h0, c});
      chk("R2 ram", ram_acc, acc0);
      get_done(dn); chk("R2 done", {31'h0, dn}, 32'h0);

      // R5: zero count completes immediately
      setup(1'b0, 1'b0, 16'h0777, 16'd0);
      acc0 = ram_acc;
      rw(4'h0, 8'h01);
      @(negedge clk);
      get_done(dn); chk("R5 zero done", {31'h0, dn}, 32'h1);
      chk("R5 zero ram", ram_acc, acc0);
      get_cur(c); chk("R5 zero addr", {16'h0, c}, 32'h0777);

      // R8: abort mid write
      setup(1'b1, 1'b0, 16'h0900, 16'd10);
      rw(4'h0, 8'h02);
      dpw(16'hA1A2);
      dpw(16'hB1B2);
      rw(4'h0, 8'h04);
      acc0 = ram_acc;
      dpw(16'hC1C2);
      dpw(16'hD1D2);
      chk("R8 ram", ram_acc, acc0);
      get_cur(c); chk("R8 addr", {16'h0, c}, 32'h0904);
      get_done(dn); chk("R8 done", {31'h0, dn}, 32'h0);
      chk("R8 mem", {24'h0, mem[16'h0904]}, {24'h0, pat(16'h0904)});

      // R8: abort mid read with code 111
      setup(1'b0, 1'b0, 16'h0A00, 16'd8);
      rw(4'h0, 8'h01);
      @(negedge clk);
      dpr(d);
      chk("R4 first", {16'h0, d}, {16'h0, exp_rd(16'h0A00, 1'b0, 1'b0)});
      rw(4'h0, 8'h07);
      acc0 = ram_acc;
      dpr(d);
      dpr(d);
      chk("R8 rd ram", ram_acc, acc0);
      get_cur(c); chk("R8 rd addr", {16'h0, c}, 32'h0A01);

      // random transfers
      for (int t = 0; t < 24; t++) begin
         xfer(1'($urandom), 1'($urandom), 1'($urandom),
              16'($urandom), 16'($urandom_range(1, 33)));
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule